// File: doc/BRIEF.md
# External Access Forwarder

This block sits between a generic register-bus requester and logic that lives outside the register file. It decodes each access and sorts it into one of three cases: a single external register slot, a window of external memory entries, or nothing at all. For a hit it latches the access and presents one request to the external side. A register request carries the register field's slice of the write data and a per-bit mask. A memory request carries an entry index and the full write data and mask. It then waits for the external acknowledge. The acknowledge, the external read data and the external error are folded back into the ready, read data and error that the requester sees.

The requester keeps its read or write valid high until it sees ready. An access to an address outside both targets is answered in the same cycle with ready and error, and no external request is raised.

The controller has three states. `ST_IDLE` decodes the bus. It moves to `ST_REG_WAIT` on a register hit and to `ST_MEM_WAIT` on a memory-window hit, and it stays put on a miss or when no valid is present. Each wait state holds its request. It returns to `ST_IDLE` on the cycle its acknowledge is sampled.

Top module: `ext_access_fwd`

## Requirements
- R1: After reset the block is in `ST_IDLE`: all four external requests are low, and with no valid present ready, error and read data are zero.
- R2: A valid in `ST_IDLE` whose address equals `REG_ADDR` raises the register write request (write valid) or read request (read valid) in the next cycle. The register write data is bus write data bits `[FLD_LSB +: FLD_W]`.
- R3: The write mask is bit-wise: mask bit i equals byte enable `i/8`. The memory mask covers all `DATA_W` bits, and the register mask is its `[FLD_LSB +: FLD_W]` slice.
- R4: A valid with `MEM_LO <= addr < MEM_HI` raises the memory read or write request in the next cycle. The entry index is `(addr - MEM_LO) / (DATA_W/8)`, and the memory write data equals the bus write data.
- R5: An external request, its index, data and mask stay asserted and unchanged until its acknowledge. Bus address, data and byte-enable changes made meanwhile have no effect on them.
- R6: In a wait state, ready equals that target's acknowledge. The cycle after the acknowledge, all requests are low.
- R7: Read data is `xm_rdata` in `ST_MEM_WAIT`. In `ST_REG_WAIT` it is `xr_rdata` placed at bits `[FLD_LSB +: FLD_W]` with the other bits zero. In every other case it is zero.
- R8: Error is high in a wait state only when the external error, that target's acknowledge, and the bus valid matching the latched operation are all high.
- R9: A valid to an address that hits neither target gives ready=1, error=1 and read data 0 in the same cycle, and raises no request. Addresses `MEM_HI` and `MEM_LO-1` are misses.
- R10: If read and write valid are both high when an access is accepted, it is forwarded as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address from the requester |
| bus_wdata | input | DATA_W | Write data from the requester |
| bus_rd | input | 1 | Read valid |
| bus_wr | input | 1 | Write valid |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_rdy | output | 1 | Access complete |
| bus_err | output | 1 | Access failed |
| bus_rdata | output | DATA_W | Read data to the requester |
| xr_wr_req | output | 1 | External register write request |
| xr_rd_req | output | 1 | External register read request |
| xr_wdata | output | FLD_W | External register write data |
| xr_wmask | output | FLD_W | External register bit write mask |
| xr_ack | input | 1 | External register acknowledge |
| xr_err | input | 1 | External register error |
| xr_rdata | input | FLD_W | External register read data |
| xm_wr_req | output | 1 | External memory write request |
| xm_rd_req | output | 1 | External memory read request |
| xm_idx | output | IDX_W | Memory entry index |
| xm_wdata | output | DATA_W | Memory write data |
| xm_wmask | output | DATA_W | Memory bit write mask |
| xm_ack | input | 1 | External memory acknowledge |
| xm_err | input | 1 | External memory error |
| xm_rdata | input | DATA_W | External memory read data |

## Verification
A hit raises its external request one clock after the valid is first sampled in `ST_IDLE`, so the bench checks request, index, data and mask at the falling edge of that next cycle, after it has scrambled the bus inputs. Ready, error and read data are combinational from the acknowledge, so they are due in the cycle the acknowledge is driven. The scoreboard monitor compares them at that cycle's falling edge against the entry pushed by the driver. A miss is answered in the very cycle of the valid. The drop of all requests is checked one cycle after the acknowledge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_REG_WAIT = 2'd1,
        ST_MEM_WAIT = 2'd2
    } fwd_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_MEM  = 2'd2
    } fwd_tgt_e;
endpackage

// File: rtl/fwd_decode.sv
module fwd_decode
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_SH = 2,
    parameter int IDX_W = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] MEM_LO = 'h100,
    parameter logic [ADDR_W-1:0] MEM_HI = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    output fwd_tgt_e          tgt,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] SPAN = MEM_HI - MEM_LO;

    logic [ADDR_W-1:0] offset;
    logic              in_window;

    // Rebase to the window start; the index is the offset in whole entries.
    assign offset    = addr - MEM_LO;
    assign in_window = (addr >= MEM_LO) && (offset < SPAN);
    assign idx       = offset[BYTE_SH +: IDX_W];

    always_comb begin
        if (addr == REG_ADDR)
            tgt = TGT_REG;
        else if (in_window)
            tgt = TGT_MEM;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/fwd_mask.sv
module fwd_mask #(
    parameter int DATA_W = 32,
    parameter int BE_W = DATA_W / 8
) (
    input  logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] mask
);
    // Each byte enable drives all eight bits of its byte.
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign mask[8*b +: 8] = {8{be[b]}};
    end
endmodule

// File: rtl/ext_access_fwd.sv
module ext_access_fwd
    import fwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int FLD_LSB = 8,
    parameter int FLD_W = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h10,
    parameter logic [ADDR_W-1:0] MEM_LO = 'h100,
    parameter logic [ADDR_W-1:0] MEM_HI = 'h200,
    localparam int BE_W = DATA_W / 8,
    localparam int BYTE_SH = $clog2(BE_W),
    localparam int IDX_W = $clog2(int'(MEM_HI - MEM_LO) >> BYTE_SH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    output logic              bus_rdy,
    output logic              bus_err,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              xr_wr_req,
    output logic              xr_rd_req,
    output logic [FLD_W-1:0]  xr_wdata,
    output logic [FLD_W-1:0]  xr_wmask,
    input  logic              xr_ack,
    input  logic              xr_err,
    input  logic [FLD_W-1:0]  xr_rdata,
    output logic              xm_wr_req,
    output logic              xm_rd_req,
    output logic [IDX_W-1:0]  xm_idx,
    output logic [DATA_W-1:0] xm_wdata,
    output logic [DATA_W-1:0] xm_wmask,
    input  logic              xm_ack,
    input  logic              xm_err,
    input  logic [DATA_W-1:0] xm_rdata
);
    fwd_state_e        st_q, st_d;
    fwd_tgt_e          tgt;
    logic [IDX_W-1:0]  idx_now;
    logic              any_vld;
    logic              accept;
    logic              cap_wr;
    logic [IDX_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_wdata;
    logic [BE_W-1:0]   cap_be;
    logic [DATA_W-1:0] full_mask;
    logic              vld_match;

    fwd_decode #(
        .ADDR_W  (ADDR_W),
        .BYTE_SH (BYTE_SH),
        .IDX_W   (IDX_W),
        .REG_ADDR(REG_ADDR),
        .MEM_LO  (MEM_LO),
        .MEM_HI  (MEM_HI)
    ) u_decode (
        .addr(bus_addr),
        .tgt (tgt),
        .idx (idx_now)
    );

    fwd_mask #(
        .DATA_W(DATA_W),
        .BE_W  (BE_W)
    ) u_mask (
        .be  (cap_be),
        .mask(full_mask)
    );

    assign any_vld   = bus_rd | bus_wr;
    assign accept    = (st_q == ST_IDLE) && any_vld && (tgt != TGT_NONE);
    assign vld_match = cap_wr ? bus_wr : bus_rd;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // Access capture: only taken in idle, so bus changes during a wait are ignored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_wr    <= 1'b0;
            cap_idx   <= '0;
            cap_wdata <= '0;
            cap_be    <= '0;
        end else if (accept) begin
            cap_wr    <= bus_wr;
            cap_idx   <= idx_now;
            cap_wdata <= bus_wdata;
            cap_be    <= bus_be;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (accept)
                    st_d = (tgt == TGT_REG) ? ST_REG_WAIT : ST_MEM_WAIT;
            end
            ST_REG_WAIT: if (xr_ack) st_d = ST_IDLE;
            ST_MEM_WAIT: if (xm_ack) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        bus_rdy   = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = '0;
        xr_wr_req = 1'b0;
        xr_rd_req = 1'b0;
        xm_wr_req = 1'b0;
        xm_rd_req = 1'b0;
        xr_wdata  = cap_wdata[FLD_LSB +: FLD_W];
        xr_wmask  = full_mask[FLD_LSB +: FLD_W];
        xm_idx    = cap_idx;
        xm_wdata  = cap_wdata;
        xm_wmask  = full_mask;
        unique case (st_q)
            ST_IDLE: begin
                if (any_vld && (tgt == TGT_NONE)) begin
                    bus_rdy = 1'b1;
                    bus_err = 1'b1;
                end
            end
            ST_REG_WAIT: begin
                xr_wr_req = cap_wr;
                xr_rd_req = !cap_wr;
                bus_rdy   = xr_ack;
                bus_err   = xr_ack & xr_err & vld_match;
                bus_rdata[FLD_LSB +: FLD_W] = xr_rdata;
            end
            ST_MEM_WAIT: begin
                xm_wr_req = cap_wr;
                xm_rd_req = !cap_wr;
                bus_rdy   = xm_ack;
                bus_err   = xm_ack & xm_err & vld_match;
                bus_rdata = xm_rdata;
            end
            default: ;
        endcase
    end

    // R5: a memory request holds with stable index, data and mask until acknowledged
    a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((xm_rd_req || xm_wr_req) && !xm_ack) |=>
            ((xm_rd_req || xm_wr_req) && $stable(xm_idx) && $stable(xm_wdata) && $stable(xm_wmask)));

    // R5: a register request holds with stable data and mask until acknowledged
    a_r5_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((xr_rd_req || xr_wr_req) && !xr_ack) |=>
            ((xr_rd_req || xr_wr_req) && $stable(xr_wdata) && $stable(xr_wmask)));

    // R6: an acknowledge releases every request in the next cycle
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (((xm_rd_req || xm_wr_req) && xm_ack) || ((xr_rd_req || xr_wr_req) && xr_ack)) |=>
            !(xm_rd_req || xm_wr_req || xr_rd_req || xr_wr_req));

    // R2/R4: at most one external request at a time
    a_r4_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xr_wr_req, xr_rd_req, xm_wr_req, xm_rd_req}));

    // R8: an error is only reported together with ready
    a_r8_err_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdy);

    // R7: read data is zero while no external request is active
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(xr_wr_req || xr_rd_req || xm_wr_req || xm_rd_req) |-> (bus_rdata == '0));
endmodule

// File: tb/ext_access_fwd_tb.sv
module ext_access_fwd_tb;
    typedef struct {
        logic        err;
        logic [31:0] rdata;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic        bus_rdy, bus_err;
    logic [31:0] bus_rdata;
    logic        xr_wr_req, xr_rd_req;
    logic [15:0] xr_wdata, xr_wmask;
    logic        xr_ack = 1'b0;
    logic        xr_err = 1'b0;
    logic [15:0] xr_rdata = '0;
    logic        xm_wr_req, xm_rd_req;
    logic [5:0]  xm_idx;
    logic [31:0] xm_wdata, xm_wmask;
    logic        xm_ack = 1'b0;
    logic        xm_err = 1'b0;
    logic [31:0] xm_rdata = '0;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    ext_access_fwd u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_rdy(bus_rdy), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .xr_wr_req(xr_wr_req), .xr_rd_req(xr_rd_req), .xr_wdata(xr_wdata),
        .xr_wmask(xr_wmask), .xr_ack(xr_ack), .xr_err(xr_err), .xr_rdata(xr_rdata),
        .xm_wr_req(xm_wr_req), .xm_rd_req(xm_rd_req), .xm_idx(xm_idx),
        .xm_wdata(xm_wdata), .xm_wmask(xm_wmask), .xm_ack(xm_ack), .xm_err(xm_err),
        .xm_rdata(xm_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = be[i/8];
        return m;
    endfunction

    // Monitor: compares every response against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && bus_rdy) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected rdy", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " err"}, {31'd0, bus_err}, {31'd0, e.err});
                chk({e.tag, " rdata"}, bus_rdata, e.rdata);
            end
        end
    end

    function automatic logic [3:0] reqs();
        return {xr_wr_req, xr_rd_req, xm_wr_req, xm_rd_req};
    endfunction

    // Driver: one access, external side answered after 'delay' extra wait cycles
    task automatic access(input logic [15:0] a, input logic [31:0] wd, input logic [3:0] be,
                          input logic rd, input logic wr, input int delay,
                          input logic eerr, input logic [31:0] erd, input logic drop);
        bit   is_reg = (a == 16'h0010);
        bit   is_mem = (a >= 16'h0100) && (a < 16'h0200);
        logic op_wr = wr;
        exp_t e;
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = wd; bus_be = be; bus_rd = rd; bus_wr = wr;
        if (!is_reg && !is_mem) begin
            e.err = 1'b1; e.rdata = '0; e.tag = "R9 miss";
            exp_q.push_back(e);
            @(negedge clk);
            chk("R9 miss no request", {28'd0, reqs()}, 32'd0);
            chk("R9 miss rdy", {31'd0, bus_rdy}, 32'd1);
            @(posedge clk); #1;
            bus_rd = 1'b0; bus_wr = 1'b0;
            return;
        end
        @(posedge clk); #1;
        // R5: scramble bus inputs while the request is outstanding
        bus_addr = a ^ 16'h0004; bus_wdata = ~wd; bus_be = ~be;
        @(negedge clk);
        if (is_reg) begin
            chk("R2/R10 reg request", {28'd0, reqs()}, {28'd0, op_wr, !op_wr, 2'b00});
            chk("R2 reg wdata slice", {16'd0, xr_wdata}, {16'd0, wd[23:8]});
            chk("R3 reg mask", {16'd0, xr_wmask}, {16'd0, bmask(be) >> 8} & 32'hFFFF);
        end else begin
            chk("R4 mem request", {28'd0, reqs()}, {30'd0, op_wr, !op_wr});
            chk("R4 mem index", {26'd0, xm_idx}, 32'(a - 16'h0100) / 4);
            chk("R4 mem wdata", xm_wdata, wd);
            chk("R3 mem mask", xm_wmask, bmask(be));
        end
        for (int k = 0; k < delay; k++) begin
            @(posedge clk); #1;
            xr_err = eerr; xm_err = eerr;
            @(negedge clk);
            chk("R5 request held", {31'd0, |reqs()}, 32'd1);
            chk("R6 no rdy without ack", {31'd0, bus_rdy}, 32'd0);
            chk("R8 no err without ack", {31'd0, bus_err}, 32'd0);
            if (is_mem) chk("R5 index unchanged", {26'd0, xm_idx}, 32'(a - 16'h0100) / 4);
            else        chk("R5 reg data unchanged", {16'd0, xr_wdata}, {16'd0, wd[23:8]});
        end
        @(posedge clk); #1;
        if (drop) begin bus_rd = 1'b0; bus_wr = 1'b0; end
        e.err = eerr && !drop;
        e.tag = is_reg ? "R7/R8 reg response" : "R7/R8 mem response";
        if (is_reg) begin
            xr_ack = 1'b1; xr_err = eerr; xr_rdata = erd[15:0];
            e.rdata = {8'd0, erd[15:0], 8'd0};
        end else begin
            xm_ack = 1'b1; xm_err = eerr; xm_rdata = erd;
            e.rdata = erd;
        end
        exp_q.push_back(e);
        @(posedge clk); #1;
        xr_ack = 1'b0; xm_ack = 1'b0; xr_err = 1'b0; xm_err = 1'b0;
        xr_rdata = '0; xm_rdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        chk("R6 requests released", {28'd0, reqs()}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset requests", {28'd0, reqs()}, 32'd0);
        chk("R1 reset rdy", {31'd0, bus_rdy}, 32'd0);
        chk("R1 reset err", {31'd0, bus_err}, 32'd0);
        chk("R1 reset rdata", bus_rdata, 32'd0);

        access(16'h0010, 32'hA1B2C3D4, 4'b0010, 0, 1, 2, 0, 32'h0, 0);     // R2 R3
        access(16'h0010, 32'h0,        4'b0100, 0, 1, 0, 0, 32'h0, 0);     // R3 upper byte
        access(16'h0010, 32'h0,        4'b1111, 1, 0, 0, 0, 32'hBEEF, 0);  // R7 reg read
        access(16'h01F4, 32'h0,        4'b1111, 1, 0, 3, 0, 32'h12345678, 0); // R4 R5 R7
        access(16'h0100, 32'hCAFEF00D, 4'b1001, 0, 1, 1, 0, 32'h0, 0);     // R4 first entry
        access(16'h01FC, 32'h55AA55AA, 4'b0011, 0, 1, 0, 0, 32'h0, 0);     // R4 last entry
        access(16'h0200, 32'h0,        4'b1111, 1, 0, 0, 0, 32'h0, 0);     // R9 upper bound
        access(16'h00FF, 32'h0,        4'b1111, 0, 1, 0, 0, 32'h0, 0);     // R9 below window
        access(16'h0140, 32'h01020304, 4'b1111, 0, 1, 2, 1, 32'h0, 0);     // R8 error with ack
        access(16'h0144, 32'h0,        4'b1111, 1, 0, 1, 1, 32'h77, 1);    // R8 valid dropped
        access(16'h0010, 32'h00FF0000, 4'b0110, 1, 1, 0, 0, 32'h0, 0);     // R10 both valids
        access(16'h0010, 32'h0,        4'b1111, 1, 0, 0, 1, 32'h1234, 0);  // R8 reg error

        repeat (2) @(negedge clk);
        chk("R6 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule